// File: doc/BRIEF.md
# Audio serial clock ratio generator

This block takes the master audio clock and derives from it the bit clock and the left/right frame clock that a serial audio transmitter needs. The master clock runs at a selectable multiple of the sample rate: 256, 384, 512 or 768 times. The block divides it down so that one frame holds a selectable number of bit clocks: 16, 24, 32 or 48. Alongside the clocks it gives the serializer a one-cycle bit strobe and a one-cycle frame-start strobe, both in the master clock domain.

In master mode the block drives both serial clocks and turns on their output enables. In slave mode it releases both pins. The strobes then come from falling edges of externally supplied bit and frame clocks, which pass through a two-stage synchronizer first. A separate direction input sets whether the codec clock pin is an output or an input.

A configuration write stores a pending ratio pair. The running frame always completes with the old settings. The new pair takes over on the first master clock of the next frame.

Top module: `aud_clk_ratio_gen`

## Requirements
- R1: While reset is held and right after it in master mode, the counters sit at the first master clock of a left half frame. `bit_stb` and `frame_stb` are 1, `bclk_o` and `lrclk_o` are 0, and both clock output enables are 1. The reset setting is ratio 256 with 32 bits per frame.
- R2: In master mode one bit period lasts `div` master clocks, where `div` is the master-to-frame ratio divided by bits per frame, rounded down. Ratio codes on `fs_code` are 0=256, 1=384, 2=512, 3=768. Bit codes on `bpf_code` are 0=16, 1=24, 2=32, 3=48.
- R3: Within each bit period `bclk_o` is low for the first `div - div/2` master clocks and high for the remaining `div/2`. This gives 50% duty whenever `div` is even.
- R4: A frame lasts bits-per-frame times `div` master clocks. `lrclk_o` is low for the first half of the bit periods (the left channel) and high for the second half.
- R5: An `fs_code` of 4 to 7 selects ratio 256.
- R6: A `bpf_code` of 4 to 7 is ignored, and the previously stored bits-per-frame setting is kept.
- R7: A write on `cfg_wr` changes nothing in the frame that is running. The new setting applies from the next `frame_stb`.
- R8: In master mode `bit_stb` is high for exactly one master clock at the start of each bit period, so a frame holds bits-per-frame of them. `frame_stb` is high only together with the `bit_stb` of the first bit.
- R9: In slave mode both clock output enables and both clock outputs are 0. `bit_stb` pulses for one cycle two master clocks after a falling edge of `ext_bclk`, and `frame_stb` does the same after a falling edge of `ext_lrclk`. Rising edges produce no strobe.
- R10: `cdclk_oe` is 0 when `cdclk_in` is 1 (codec clock pin is an input) and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Stores the two ratio codes as the pending setting |
| fs_code | input | 3 | Master-to-frame ratio code |
| bpf_code | input | 3 | Bit-clocks-per-frame code |
| master_mode | input | 1 | 1 = drive serial clocks, 0 = follow external clocks |
| cdclk_in | input | 1 | 1 = codec clock pin is an input |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| lrclk_o | output | 1 | Generated frame clock |
| lrclk_oe | output | 1 | Frame clock output enable |
| bit_stb | output | 1 | One-cycle strobe at the start of each bit |
| frame_stb | output | 1 | One-cycle strobe at the start of each frame |
| cdclk_oe | output | 1 | Codec clock pin output enable |

## Verification
In master mode the outputs decode the counters directly. They are therefore valid in the same cycle as the counter state, and a changed setting appears on the first cycle of the frame after the write. The bench samples every output on the falling clock edge. It measures whole frames from one `frame_stb` to the next, counting bit-clock low and high cycles, strobes and frame-clock high cycles. In slave mode a strobe is due on the second falling edge after the external edge is driven, and the bench checks that it is absent on the first and third. The codec pin enable and the output enables are checked one time step after their inputs change, because no register lies on their paths.

// File: rtl/aud_clk_ratio_gen.sv
module aud_clk_ratio_gen #(
  parameter int CW = 6
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] fs_code,
  input  logic [2:0] bpf_code,
  input  logic       master_mode,
  input  logic       cdclk_in,
  input  logic       ext_bclk,
  input  logic       ext_lrclk,
  output logic       bclk_o,
  output logic       bclk_oe,
  output logic       lrclk_o,
  output logic       lrclk_oe,
  output logic       bit_stb,
  output logic       frame_stb,
  output logic       cdclk_oe
);
  logic [1:0]    pend_fs, pend_bp, act_fs, act_bp;
  logic [CW-1:0] div, bpf, dcnt, bcnt;
  logic [2:0]    bsync, lsync;

  always_comb begin
    unique case (act_bp)
      2'd0:    bpf = CW'(16);
      2'd1:    bpf = CW'(24);
      2'd2:    bpf = CW'(32);
      default: bpf = CW'(48);
    endcase
    unique case ({act_fs, act_bp})
      4'h0: div = CW'(16);
      4'h1: div = CW'(10);
      4'h2: div = CW'(8);
      4'h3: div = CW'(5);
      4'h4: div = CW'(24);
      4'h5: div = CW'(16);
      4'h6: div = CW'(12);
      4'h7: div = CW'(8);
      4'h8: div = CW'(32);
      4'h9: div = CW'(21);
      4'hA: div = CW'(16);
      4'hB: div = CW'(10);
      4'hC: div = CW'(48);
      4'hD: div = CW'(32);
      4'hE: div = CW'(24);
      default: div = CW'(16);
    endcase
  end

  wire bit_end   = dcnt == div - CW'(1);
  wire frame_end = bit_end && (bcnt == bpf - CW'(1));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pend_fs <= 2'd0;
      pend_bp <= 2'd2;
      act_fs  <= 2'd0;
      act_bp  <= 2'd2;
      dcnt    <= '0;
      bcnt    <= '0;
      bsync   <= '0;
      lsync   <= '0;
    end else begin
      bsync <= {bsync[1:0], ext_bclk};
      lsync <= {lsync[1:0], ext_lrclk};
      if (cfg_wr) begin
        pend_fs <= fs_code[2] ? 2'd0 : fs_code[1:0];
        if (!bpf_code[2]) pend_bp <= bpf_code[1:0];
      end
      if (!master_mode) begin
        dcnt   <= '0;
        bcnt   <= '0;
        act_fs <= pend_fs;
        act_bp <= pend_bp;
      end else if (bit_end) begin
        dcnt <= '0;
        if (frame_end) begin
          bcnt   <= '0;
          act_fs <= pend_fs;
          act_bp <= pend_bp;
        end else begin
          bcnt <= bcnt + CW'(1);
        end
      end else begin
        dcnt <= dcnt + CW'(1);
      end
    end
  end

  assign bclk_oe   = master_mode;
  assign lrclk_oe  = master_mode;
  assign bclk_o    = master_mode && (dcnt >= div - (div >> 1));
  assign lrclk_o   = master_mode && (bcnt >= (bpf >> 1));
  assign bit_stb   = master_mode ? (dcnt == '0) : (bsync[2] & ~bsync[1]);
  assign frame_stb = master_mode ? (dcnt == '0 && bcnt == '0) : (lsync[2] & ~lsync[1]);
  assign cdclk_oe  = ~cdclk_in;
endmodule

// File: rtl/aud_clk_ratio_chk.sv
module aud_clk_ratio_chk (
  input logic       mclk,
  input logic       rst_n,
  input logic       master_mode,
  input logic       bclk_o,
  input logic       lrclk_o,
  input logic       bit_stb,
  input logic       frame_stb,
  input logic [1:0] act_fs,
  input logic [1:0] act_bp
);
  p_frame_on_bit_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && frame_stb) |-> bit_stb);

  p_single_bit_stb_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && bit_stb) |=> (!bit_stb || !master_mode));

  p_bclk_low_at_start_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && bit_stb) |-> !bclk_o);

  p_left_at_frame_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && frame_stb) |-> !lrclk_o);

  p_hold_mid_frame_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && !frame_stb) |-> ($stable(act_fs) && $stable(act_bp)));

  p_slave_quiet_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    !master_mode |-> (!bclk_o && !lrclk_o));
endmodule

bind aud_clk_ratio_gen aud_clk_ratio_chk chk_i (
  .mclk(mclk), .rst_n(rst_n), .master_mode(master_mode),
  .bclk_o(bclk_o), .lrclk_o(lrclk_o), .bit_stb(bit_stb),
  .frame_stb(frame_stb), .act_fs(act_fs), .act_bp(act_bp)
);

// File: tb/aud_clk_ratio_gen_tb_top.sv
module aud_clk_ratio_gen_tb_top;
  logic mclk = 0, rst_n = 0, cfg_wr = 0, master_mode = 1, cdclk_in = 0;
  logic ext_bclk = 1, ext_lrclk = 1;
  logic [2:0] fs_code = 0, bpf_code = 0;
  logic bclk_o, bclk_oe, lrclk_o, lrclk_oe, bit_stb, frame_stb, cdclk_oe;
  int checks = 0, errors = 0;

  always #5 mclk = ~mclk;

  aud_clk_ratio_gen dut_i (
    .mclk(mclk), .rst_n(rst_n), .cfg_wr(cfg_wr), .fs_code(fs_code),
    .bpf_code(bpf_code), .master_mode(master_mode), .cdclk_in(cdclk_in),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk), .bclk_o(bclk_o),
    .bclk_oe(bclk_oe), .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe),
    .bit_stb(bit_stb), .frame_stb(frame_stb), .cdclk_oe(cdclk_oe)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic set_cfg(input int fs, input int bp);
    @(negedge mclk);
    fs_code = 3'(fs); bpf_code = 3'(bp); cfg_wr = 1;
    @(negedge mclk);
    cfg_wr = 0;
  endtask

  task automatic measure_frame(input int ediv, input int ebpf, input string rq);
    int len = 0, lo = 0, hi = 0, nb = 0, lrh = 0;
    @(negedge mclk);
    while (!frame_stb) @(negedge mclk);
    chk(lrclk_o == 0, {rq, " R4 left at start"}, lrclk_o, 0);
    do begin
      if (len < ediv) begin
        if (bclk_o) hi++; else lo++;
      end
      nb += bit_stb;
      lrh += lrclk_o;
      len++;
      @(negedge mclk);
    end while (!frame_stb && len < 5000);
    chk(len == ediv * ebpf, {rq, " R2 R4 frame length"}, len, ediv * ebpf);
    chk(lo == ediv - ediv / 2, {rq, " R3 bclk low"}, lo, ediv - ediv / 2);
    chk(hi == ediv / 2, {rq, " R3 bclk high"}, hi, ediv / 2);
    chk(nb == ebpf, {rq, " R8 bit strobes"}, nb, ebpf);
    chk(lrh == (ebpf / 2) * ediv, {rq, " R4 lrclk high"}, lrh, (ebpf / 2) * ediv);
  endtask

  task automatic t_reset;
    #1;
    chk(bit_stb && frame_stb, "R1 strobes in reset", {bit_stb, frame_stb}, 3);
    chk(!bclk_o && !lrclk_o, "R1 clocks low", {bclk_o, lrclk_o}, 0);
    chk(bclk_oe && lrclk_oe, "R1 enables", {bclk_oe, lrclk_oe}, 3);
    @(negedge mclk); rst_n = 1; #1;
    chk(bit_stb && frame_stb, "R1 strobes after reset", {bit_stb, frame_stb}, 3);
    measure_frame(256 / 32, 32, "R1 default");
  endtask

  task automatic t_ratios;
    set_cfg(0, 0); measure_frame(256 / 16, 16, "R2 256/16");
    set_cfg(1, 1); measure_frame(384 / 24, 24, "R2 384/24");
    set_cfg(2, 1); measure_frame(512 / 24, 24, "R2 512/24");
    set_cfg(0, 3); measure_frame(256 / 48, 48, "R3 256/48");
    set_cfg(3, 3); measure_frame(768 / 48, 48, "R2 768/48");
    set_cfg(2, 0); measure_frame(512 / 16, 16, "R2 512/16");
  endtask

  task automatic t_invalid;
    set_cfg(6, 1); measure_frame(256 / 24, 24, "R5 fs code 6");
    set_cfg(0, 0); measure_frame(256 / 16, 16, "R6 setup");
    set_cfg(3, 5); measure_frame(768 / 16, 16, "R6 bpf code 5 kept");
  endtask

  task automatic t_boundary;
    int k = 0;
    set_cfg(0, 2); measure_frame(8, 32, "R7 setup");
    repeat (20) @(negedge mclk);
    set_cfg(1, 1);
    while (!frame_stb && k < 5000) begin @(negedge mclk); k++; end
    chk(k == 256 - 22, "R7 old frame completes", k, 256 - 22);
    measure_frame(16, 24, "R7 new setting");
  endtask

  task automatic t_slave;
    @(negedge mclk); master_mode = 0; ext_bclk = 1; ext_lrclk = 1;
    repeat (4) @(negedge mclk);
    chk(!bclk_oe && !lrclk_oe, "R9 enables off", {bclk_oe, lrclk_oe}, 0);
    chk(!bclk_o && !lrclk_o && !bit_stb, "R9 quiet", {bclk_o, lrclk_o, bit_stb}, 0);
    ext_bclk = 0;
    @(negedge mclk); chk(!bit_stb, "R9 bit stb early", bit_stb, 0);
    @(negedge mclk); chk(bit_stb && !frame_stb, "R9 bit stb due", {bit_stb, frame_stb}, 2);
    @(negedge mclk); chk(!bit_stb, "R9 bit stb one cycle", bit_stb, 0);
    ext_bclk = 1;
    @(negedge mclk); @(negedge mclk);
    chk(!bit_stb, "R9 rising edge no stb", bit_stb, 0);
    ext_lrclk = 0;
    @(negedge mclk); chk(!frame_stb, "R9 frame stb early", frame_stb, 0);
    @(negedge mclk); chk(frame_stb, "R9 frame stb due", frame_stb, 1);
    @(negedge mclk); chk(!frame_stb, "R9 frame stb one cycle", frame_stb, 0);
    master_mode = 1; #1;
    chk(frame_stb && bclk_oe, "R1 master restart", {frame_stb, bclk_oe}, 3);
    measure_frame(16, 24, "R8 after slave");
  endtask

  task automatic t_cdclk;
    @(negedge mclk); cdclk_in = 1; #1;
    chk(cdclk_oe == 0, "R10 input", cdclk_oe, 0);
    cdclk_in = 0; #1;
    chk(cdclk_oe == 1, "R10 output", cdclk_oe, 1);
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_invalid();
    t_boundary();
    t_slave();
    t_cdclk();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule